// File: doc/BRIEF.md
# Page-Fault Frequency Classifier

This block decides, each time a code page fault occurs, whether the missing page should be copied into main memory or left in flash and executed in place. It keeps a sliding window of the page numbers of the most recent faults. On a fault it counts how many times the faulting page number already appears in that window. It then compares the count with a programmable threshold.

Only a count strictly above the threshold marks the page as frequently used, and such a page is loaded. Any other count gives execute-in-place. The decision, the count and the page number come out on registered outputs one cycle after the fault strobe. On the same clock edge the page number enters the window and the oldest entry drops out. Cycles without a fault leave the window unchanged. The page loader, the memory map and the flash interface stay outside this block.

Top module: `pfault_freq_cls`

## Requirements
- R1: After reset `dec_vld` is 0, the window holds no valid entries, and the threshold equals the parameter `THR_INIT` (default 1). The first fault after reset therefore reports a count of 0 and execute-in-place.
- R2: `dec_vld` is 1 in the cycle that directly follows each cycle with `fault_vld` = 1, and it is 0 in every other cycle.
- R3: `dec_count` equals the number of valid window entries that match the faulting page, counted before that page is inserted.
- R4: `dec_load` = 1 (load into memory) exactly when `dec_count` is strictly greater than the threshold in force. Otherwise `dec_load` = 0 (execute in place).
- R5: A count equal to the threshold gives `dec_load` = 0.
- R6: The window holds the last `HIST_DEPTH` faults (default 8). After `HIST_DEPTH` newer faults, an older fault is no longer counted.
- R7: A write on `thr_wr_en` takes effect for faults in later cycles. A fault in the same cycle as the write is judged against the previous threshold.
- R8: `dec_page` repeats the page number of the fault that the decision belongs to.
- R9: Cycles without a fault do not age or change the window.
- R10: `dec_count` never exceeds `HIST_DEPTH`. With the threshold set to `HIST_DEPTH`, no page is ever loaded, even when the window is full of that page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | CNT_W | New threshold value |
| fault_vld | input | 1 | A page fault is presented this cycle |
| fault_page | input | PAGE_W | Faulting page number |
| dec_vld | output | 1 | Decision valid (one cycle after the fault) |
| dec_load | output | 1 | 1 = load into main memory, 0 = execute in place |
| dec_page | output | PAGE_W | Page number the decision belongs to |
| dec_count | output | CNT_W | Occurrences found in the window |

## Verification
The assertions check the relationships that hold on every cycle. These are the one-cycle pairing of fault strobe and decision valid, the page echo, the upper bound on the count, and the strict comparison between the reported count and the threshold that was in force. The bench scenarios are the only way to show that the count matches the real history. That covers aging past the window depth, idle cycles that do not age the window, reset clearing the history, and the timing of a threshold write that lands in the same cycle as a fault.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
package pfc_pkg;

  typedef enum logic {
    PFC_XIP  = 1'b0,
    PFC_LOAD = 1'b1
  } pfc_dec_e;

  function automatic int unsigned pfc_cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/pfc_hist_window.sv
`timescale 1ns/1ps
module pfc_hist_window #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PAGE_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [PAGE_W-1:0] push_page,
  input  logic [PAGE_W-1:0] probe_page,
  output logic [DEPTH-1:0]  hit_vec
);

  logic [PAGE_W-1:0] page_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  // Shift register: slot 0 is newest, slot DEPTH-1 oldest.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (push_en) begin
      vld_q[0] <= 1'b1;
      for (int i = 1; i < DEPTH; i++) vld_q[i] <= vld_q[i-1];
    end
  end

  // Page data needs no reset; valid bits qualify it.
  always_ff @(posedge clk) begin
    if (push_en) begin
      page_q[0] <= push_page;
      for (int i = 1; i < DEPTH; i++) page_q[i] <= page_q[i-1];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gen_cmp
      assign hit_vec[g] = vld_q[g] && (page_q[g] == probe_page);
    end
  endgenerate

endmodule

// File: rtl/pfc_hit_count.sv
`timescale 1ns/1ps
module pfc_hit_count #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic [DEPTH-1:0] hit_vec,
  output logic [CNT_W-1:0] hit_cnt
);

  always_comb begin
    hit_cnt = '0;
    for (int i = 0; i < DEPTH; i++) hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
  end

endmodule

// File: rtl/pfc_decide.sv
`timescale 1ns/1ps
module pfc_decide
  import pfc_pkg::*;
#(
  parameter int unsigned PAGE_W = 20,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fault_vld,
  input  logic [PAGE_W-1:0] fault_page,
  input  logic [CNT_W-1:0]  hit_cnt,
  input  logic [CNT_W-1:0]  thr,
  output logic              dec_vld,
  output logic              dec_load,
  output logic [PAGE_W-1:0] dec_page,
  output logic [CNT_W-1:0]  dec_count
);

  pfc_dec_e verdict;
  assign verdict = (hit_cnt > thr) ? PFC_LOAD : PFC_XIP;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_vld   <= 1'b0;
      dec_load  <= 1'b0;
      dec_page  <= '0;
      dec_count <= '0;
    end else begin
      dec_vld <= fault_vld;
      if (fault_vld) begin
        dec_load  <= (verdict == PFC_LOAD);
        dec_page  <= fault_page;
        dec_count <= hit_cnt;
      end
    end
  end

endmodule

// File: rtl/pfault_freq_cls.sv
`timescale 1ns/1ps
module pfault_freq_cls
  import pfc_pkg::*;
#(
  parameter int unsigned PAGE_W     = 20,
  parameter int unsigned HIST_DEPTH = 8,
  parameter int unsigned CNT_W      = pfc_cnt_bits(HIST_DEPTH),
  parameter int unsigned THR_INIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_wr_en,
  input  logic [CNT_W-1:0]  thr_wr_data,
  input  logic              fault_vld,
  input  logic [PAGE_W-1:0] fault_page,
  output logic              dec_vld,
  output logic              dec_load,
  output logic [PAGE_W-1:0] dec_page,
  output logic [CNT_W-1:0]  dec_count
);

  logic [CNT_W-1:0]      thr_q;
  logic [HIST_DEPTH-1:0] hit_vec;
  logic [CNT_W-1:0]      hit_cnt;

  always_ff @(posedge clk) begin
    if (rst)            thr_q <= CNT_W'(THR_INIT);
    else if (thr_wr_en) thr_q <= thr_wr_data;
  end

  pfc_hist_window #(.DEPTH(HIST_DEPTH), .PAGE_W(PAGE_W)) u_win (
    .clk        (clk),
    .rst        (rst),
    .push_en    (fault_vld),
    .push_page  (fault_page),
    .probe_page (fault_page),
    .hit_vec    (hit_vec)
  );

  pfc_hit_count #(.DEPTH(HIST_DEPTH), .CNT_W(CNT_W)) u_cnt (
    .hit_vec (hit_vec),
    .hit_cnt (hit_cnt)
  );

  pfc_decide #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .fault_vld  (fault_vld),
    .fault_page (fault_page),
    .hit_cnt    (hit_cnt),
    .thr        (thr_q),
    .dec_vld    (dec_vld),
    .dec_load   (dec_load),
    .dec_page   (dec_page),
    .dec_count  (dec_count)
  );

endmodule

// File: rtl/pfc_checker.sv
`timescale 1ns/1ps
module pfc_checker #(
  parameter int unsigned PAGE_W     = 20,
  parameter int unsigned HIST_DEPTH = 8,
  parameter int unsigned CNT_W      = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fault_vld,
  input logic [PAGE_W-1:0] fault_page,
  input logic              dec_vld,
  input logic              dec_load,
  input logic [PAGE_W-1:0] dec_page,
  input logic [CNT_W-1:0]  dec_count,
  input logic [CNT_W-1:0]  thr_q
);

  AST_DEC_FOLLOWS_FAULT: assert property (@(posedge clk) disable iff (rst)
    fault_vld |=> dec_vld); // R2

  AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (rst)
    !fault_vld |=> !dec_vld); // R2

  AST_PAGE_ECHO: assert property (@(posedge clk) disable iff (rst)
    fault_vld |=> (dec_page == $past(fault_page))); // R8

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    dec_vld |-> (dec_count <= CNT_W'(HIST_DEPTH))); // R10

  AST_LOAD_STRICT: assert property (@(posedge clk) disable iff (rst)
    fault_vld |=> (dec_load == (dec_count > $past(thr_q)))); // R4

  AST_EQUAL_IS_XIP: assert property (@(posedge clk) disable iff (rst)
    fault_vld |=> ((dec_count == $past(thr_q)) -> !dec_load)); // R5

endmodule

bind pfault_freq_cls pfc_checker #(
  .PAGE_W(PAGE_W), .HIST_DEPTH(HIST_DEPTH), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .fault_vld(fault_vld), .fault_page(fault_page),
  .dec_vld(dec_vld), .dec_load(dec_load), .dec_page(dec_page),
  .dec_count(dec_count), .thr_q(thr_q)
);

// File: tb/pfault_freq_cls_tb_top.sv
`timescale 1ns/1ps
module pfault_freq_cls_tb_top;

  localparam int PAGE_W = 20;
  localparam int H      = 8;
  localparam int CNT_W  = $clog2(H + 1);

  logic              clk = 1'b0;
  logic              rst;
  logic              thr_wr_en;
  logic [CNT_W-1:0]  thr_wr_data;
  logic              fault_vld;
  logic [PAGE_W-1:0] fault_page;
  logic              dec_vld;
  logic              dec_load;
  logic [PAGE_W-1:0] dec_page;
  logic [CNT_W-1:0]  dec_count;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;

  int hist[$];
  int thr_m;

  always #4 clk = ~clk;

  pfault_freq_cls #(.PAGE_W(PAGE_W), .HIST_DEPTH(H)) dut_i (
    .clk(clk), .rst(rst), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .fault_vld(fault_vld), .fault_page(fault_page), .dec_vld(dec_vld),
    .dec_load(dec_load), .dec_page(dec_page), .dec_count(dec_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_count(input int p);
    int n = 0;
    foreach (hist[i]) if (hist[i] == p) n++;
    return n;
  endfunction

  function automatic void model_push(input int p);
    hist.push_front(p);
    if (hist.size() > H) void'(hist.pop_back());
  endfunction

  // Called at a negedge; returns at the next negedge after checking.
  task automatic do_fault(input int p, input string tag, input bit wr_thr = 0,
                          input int new_thr = 0);
    int ec;
    bit el;
    ec = model_count(p);
    el = (ec > thr_m);
    fault_vld  = 1'b1;
    fault_page = PAGE_W'(p);
    if (wr_thr) begin
      thr_wr_en   = 1'b1;
      thr_wr_data = CNT_W'(new_thr);
    end
    @(negedge clk);
    fault_vld = 1'b0;
    thr_wr_en = 1'b0;
    model_push(p);
    if (wr_thr) thr_m = new_thr;
    chk({tag, " R2 dec_vld"}, int'(dec_vld), 1);
    chk({tag, " R3 count"}, int'(dec_count), ec);
    chk({tag, " R4 load"}, int'(dec_load), int'(el));
    chk({tag, " R8 page"}, int'(dec_page), p);
  endtask

  task automatic set_thr(input int v);
    thr_wr_en   = 1'b1;
    thr_wr_data = CNT_W'(v);
    @(negedge clk);
    thr_wr_en = 1'b0;
    thr_m = v;
  endtask

  task automatic t_reset;
    chk("R1 dec_vld after reset", int'(dec_vld), 0);
    do_fault(5, "R1 first fault");
    chk("R1 first fault is XIP", int'(dec_load), 0);
  endtask

  task automatic t_repeat;
    set_thr(1);
    do_fault(7, "R3 rep0");
    do_fault(7, "R5 rep1 equal thr");
    chk("R5 count equal thr gives XIP", int'(dec_load), 0);
    do_fault(7, "R4 rep2");
    chk("R4 above thr loads", int'(dec_load), 1);
  endtask

  task automatic t_aging;
    set_thr(0);
    do_fault(100, "R6 seed");
    for (int i = 0; i < H - 1; i++) do_fault(200 + i, "R6 fill");
    do_fault(100, "R6 last in window");
    chk("R6 oldest still counted", int'(dec_count), 1);
    for (int i = 0; i < H; i++) do_fault(300 + i, "R6 flush");
    do_fault(100, "R6 aged out");
    chk("R6 aged entry dropped", int'(dec_count), 0);
  endtask

  task automatic t_idle;
    do_fault(42, "R9 before idle");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R2 no decision while idle", int'(dec_vld), 0);
    end
    do_fault(42, "R9 after idle");
    chk("R9 idle does not age", int'(dec_count), 1);
  endtask

  task automatic t_thr_same_cycle;
    set_thr(0);
    do_fault(9, "R7 prime");
    do_fault(9, "R7 same cycle write", 1'b1, 3);
    chk("R7 old thr used", int'(dec_load), 1);
    do_fault(9, "R7 new thr");
    chk("R7 new thr applied", int'(dec_load), 0);
  endtask

  task automatic t_thr_max;
    set_thr(H);
    for (int i = 0; i < H; i++) do_fault(55, "R10 fill same");
    do_fault(55, "R10 full window");
    chk("R10 count saturates at depth", int'(dec_count), H);
    chk("R10 never loads at thr=depth", int'(dec_load), 0);
  endtask

  task automatic t_rst_clears;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hist.delete();
    thr_m = 1;
    do_fault(55, "R1 reset clears window");
    chk("R1 window empty after reset", int'(dec_count), 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL WDOG: run hung actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; thr_wr_en = 1'b0; thr_wr_data = '0;
    fault_vld = 1'b0; fault_page = '0; thr_m = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_repeat();
    t_aging();
    t_idle();
    t_thr_same_cycle();
    t_thr_max();
    t_rst_clears();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule